// File: doc/BRIEF.md
# Dual-Output Waveform Timer Channel

The block is one timer channel set up as a pulse-width generator. An up-counter advances on a selectable prescaled tick and runs from zero up to a period compare value, then returns to zero. Two waveform outputs share that period. Each output changes level according to programmable actions tied to three events. The first is its own duty compare. The second is the period compare. The third is a software trigger issued through the command register.

Software writes five word-addressed registers over a write-only register bus: a mode word, three compare values and a command word. A software trigger restarts the counter and the prescaler and forces each output to a programmed level. Clock enable and clock disable start and stop counting. With normal polarity, a duty compare clears the output and the period compare sets it. For inverted polarity those two actions are swapped. When neither compare action is programmed, the output keeps the level left by the last trigger. This covers duty equal to zero and duty equal to the period.

Top module: `wave_timer_chan`

## Requirements
- R1: After reset, `wave_a_o` and `wave_b_o` are low, `count_o` is 0 and the channel is stopped.
- R2: A write with `wr_en_i` high takes effect at that clock edge; address 0 is the mode word, 1 is the output-A duty compare, 2 is the output-B duty compare, 3 is the period compare, 4 is the command word. While running with waveform enabled, the counter advances by one on each selected tick and goes to 0 on the tick where it equals the period compare; it holds otherwise.
- R3: Mode bits [2:0] select the tick: 0 every cycle, 1 every 2nd cycle, 2 every 8th, 3 every 32nd, 4 the `slow_tick_i` input, 5 to 7 no tick. A trigger restarts the prescaler, so with divide N the first tick falls N cycles after the trigger edge.
- R4: Output actions use the 2-bit code 00 none, 01 set, 10 clear, 11 toggle. Output A takes its duty-compare action from mode bits [5:4], its period-compare action from [7:6] and its trigger action from [9:8]. Output B uses [11:10], [13:12] and [15:14] in the same way. A compare event occurs on a tick where the counter equals the compare value.
- R5: Command bit 2 (trigger) sets the counter to 0 and applies each output's trigger action at the write edge.
- R6: When events coincide, the trigger wins over the period compare, and the period compare wins over the duty compare.
- R7: Command bit 0 starts counting and bit 1 stops it; bit 1 wins when both are set. Trigger plus stop forces the outputs, zeroes the counter and leaves it at 0. Stop without trigger freezes the count, and a later start resumes from the frozen value.
- R8: With no compare actions programmed, an output holds its trigger level for any number of periods.
- R9: Mode bit 3 enables waveform counting; while it is 0 the counter and the outputs do not change except by trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slow_tick_i | input | 1 | Slow clock enable pulse, used when tick select is 4 |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register word address |
| wr_data_i | input | 32 | Register write data |
| count_o | output | 16 | Counter value |
| wave_a_o | output | 1 | Waveform output A |
| wave_b_o | output | 1 | Waveform output B |

## Verification
The main function is tried with normal and inverted polarity running together. The duty values differ between the outputs, which tells apart the per-output compare sources and their shared period. Divide-by-2, divide-by-8 and slow-tick runs, with the slow tick held both low and high, separate the tick-select codes. Toggle, zero-duty, full-duty and duty-equal-to-period patterns separate the action codes and the compare-over-compare priority. A trigger issued exactly when the counter sits on the period value exposes the trigger priority. Stop-only and start-only sequences show that the count is frozen and then resumed rather than restarted.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_SET  = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_TGL  = 2'b11
  } act_e;

  // per-output action set; msb first
  typedef struct packed {
    act_e on_trig;
    act_e on_cmpc;
    act_e on_cmpx;
  } out_cfg_t;

  typedef struct packed {
    out_cfg_t   b;
    out_cfg_t   a;
    logic       wave_en;
    logic [2:0] clk_sel;
  } mode_t;

  localparam int MODE_W    = $bits(mode_t);
  localparam int ADDR_MODE = 0;
  localparam int ADDR_CMPA = 1;
  localparam int ADDR_CMPB = 2;
  localparam int ADDR_CMPC = 3;
  localparam int ADDR_CMD  = 4;
  localparam int CMD_EN    = 0;
  localparam int CMD_DIS   = 1;
  localparam int CMD_TRIG  = 2;
endpackage

// File: rtl/wtc_prescaler.sv
module wtc_prescaler #(
  parameter int PRE_W = 5,
  parameter int SH1   = 1,
  parameter int SH2   = 3,
  parameter int SH3   = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       restart_i,
  input  logic [2:0] sel_i,
  input  logic       slow_tick_i,
  output logic       tick_o
);
  localparam int NTAP = 4;
  localparam int SH [NTAP] = '{0, SH1, SH2, SH3};

  logic [PRE_W-1:0] pre_q;
  logic [NTAP-1:0]  tap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pre_q <= '0;
    else if (restart_i) pre_q <= '0;
    else                pre_q <= pre_q + 1'b1;
  end

  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    localparam logic [PRE_W-1:0] MASK = PRE_W'((1 << SH[g]) - 1);
    assign tap[g] = &(pre_q | ~MASK);
  end

  always_comb begin
    case (sel_i)
      3'd0, 3'd1, 3'd2, 3'd3: tick_o = tap[sel_i[1:0]];
      3'd4:                   tick_o = slow_tick_i;
      default:                tick_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/wtc_counter.sv
module wtc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] ra_i,
  input  logic [CNT_W-1:0] rb_i,
  input  logic [CNT_W-1:0] rc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_a_o,
  output logic             hit_b_o,
  output logic             hit_c_o
);
  logic [CNT_W-1:0] cnt_q;

  assign hit_a_o = step_i && (cnt_q == ra_i);
  assign hit_b_o = step_i && (cnt_q == rb_i);
  assign hit_c_o = step_i && (cnt_q == rc_i);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (hit_c_o)   cnt_q <= '0;
    else if (step_i)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wtc_out_unit.sv
module wtc_out_unit
  import wtc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  out_cfg_t cfg_i,
  input  logic     trig_i,
  input  logic     hit_c_i,
  input  logic     hit_x_i,
  output logic     wave_o
);
  act_e act;
  logic wave_q;

  always_comb begin
    if (trig_i)       act = cfg_i.on_trig;
    else if (hit_c_i) act = cfg_i.on_cmpc;
    else if (hit_x_i) act = cfg_i.on_cmpx;
    else              act = ACT_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wave_q <= 1'b0;
    else begin
      case (act)
        ACT_SET: wave_q <= 1'b1;
        ACT_CLR: wave_q <= 1'b0;
        ACT_TGL: wave_q <= ~wave_q;
        default: wave_q <= wave_q;
      endcase
    end
  end

  assign wave_o = wave_q;
endmodule

// File: rtl/wave_timer_chan.sv
module wave_timer_chan
  import wtc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int PRE_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slow_tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              wave_a_o,
  output logic              wave_b_o
);
  localparam int NOUT = 2;

  mode_t            mode_q;
  logic [CNT_W-1:0] ra_q, rb_q, rc_q;
  logic             running_q;
  logic             cmd_wr, trig_w, tick_w, step_w;
  logic [NOUT-1:0]  hit_x, wave;
  logic             hit_a, hit_b, hit_c;
  out_cfg_t         cfg_arr [NOUT];

  assign cmd_wr = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_CMD));
  assign trig_w = cmd_wr && wr_data_i[CMD_TRIG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      ra_q   <= '0;
      rb_q   <= '0;
      rc_q   <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        ADDR_W'(ADDR_MODE): mode_q <= mode_t'(wr_data_i[MODE_W-1:0]);
        ADDR_W'(ADDR_CMPA): ra_q   <= wr_data_i[CNT_W-1:0];
        ADDR_W'(ADDR_CMPB): rb_q   <= wr_data_i[CNT_W-1:0];
        ADDR_W'(ADDR_CMPC): rc_q   <= wr_data_i[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  // stop wins over start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) running_q <= 1'b0;
    else if (cmd_wr) begin
      if (wr_data_i[CMD_DIS])     running_q <= 1'b0;
      else if (wr_data_i[CMD_EN]) running_q <= 1'b1;
    end
  end

  wtc_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .restart_i   (trig_w),
    .sel_i       (mode_q.clk_sel),
    .slow_tick_i (slow_tick_i),
    .tick_o      (tick_w)
  );

  assign step_w = tick_w && running_q && mode_q.wave_en;

  wtc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (trig_w),
    .step_i    (step_w),
    .ra_i      (ra_q),
    .rb_i      (rb_q),
    .rc_i      (rc_q),
    .cnt_o     (count_o),
    .hit_a_o   (hit_a),
    .hit_b_o   (hit_b),
    .hit_c_o   (hit_c)
  );

  assign cfg_arr[0] = mode_q.a;
  assign cfg_arr[1] = mode_q.b;
  assign hit_x      = {hit_b, hit_a};

  for (genvar g = 0; g < NOUT; g++) begin : g_out
    wtc_out_unit u_out (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cfg_i   (cfg_arr[g]),
      .trig_i  (trig_w),
      .hit_c_i (hit_c),
      .hit_x_i (hit_x[g]),
      .wave_o  (wave[g])
    );
  end

  assign wave_a_o = wave[0];
  assign wave_b_o = wave[1];
endmodule

// File: rtl/wtc_chk.sv
module wtc_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             trig_i,
  input logic             dis_wr_i,
  input logic             step_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] rc_i,
  input logic             running_i,
  input logic [1:0]       a_trig_act_i,
  input logic [1:0]       b_trig_act_i,
  input logic             a_i,
  input logic             b_i
);
  // R2
  wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && (cnt_i == rc_i) && !trig_i |=> cnt_i == '0);

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i && !trig_i |=> $stable(cnt_i));

  // R5
  trig_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> cnt_i == '0);

  // R7
  stop_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_wr_i |=> !running_i);

  // R5
  trig_set_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i && (a_trig_act_i == 2'b01) |=> a_i);

  // R5
  trig_clr_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i && (b_trig_act_i == 2'b10) |=> !b_i);
endmodule

bind wave_timer_chan wtc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .trig_i       (trig_w),
  .dis_wr_i     (cmd_wr && wr_data_i[wtc_pkg::CMD_DIS]),
  .step_i       (step_w),
  .cnt_i        (count_o),
  .rc_i         (rc_q),
  .running_i    (running_q),
  .a_trig_act_i (mode_q.a.on_trig),
  .b_trig_act_i (mode_q.b.on_trig),
  .a_i          (wave_a_o),
  .b_i          (wave_b_o)
);

// File: tb/tb_wave_timer_chan.sv
`timescale 1ns/1ps
module tb_wave_timer_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [15:0] count;
  logic        wave_a, wave_b;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  wave_timer_chan dut (
    .clk_i(clk), .rst_ni(rst_n), .slow_tick_i(slow_tick),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .count_o(count), .wave_a_o(wave_a), .wave_b_o(wave_b)
  );

  typedef struct {
    logic  a;
    logic  b;
    int    cnt;
    string tag;
  } item_t;
  item_t sb_q[$];

  // bench view of configuration and state
  logic [2:0] m_sel;
  logic       m_we;
  logic [1:0] a_x, a_c, a_t, b_x, b_c, b_t;
  int cfg_ra, cfg_rb, cfg_rc;
  logic cur_a = 0, cur_b = 0;
  int   cur_cnt = 0;
  bit   cur_run = 0;

  function automatic logic apply_act(logic [1:0] act, logic lvl);
    case (act)
      2'b01:   return 1'b1;
      2'b10:   return 1'b0;
      2'b11:   return ~lvl;
      default: return lvl;
    endcase
  endfunction

  // R6: period compare checked before duty compare
  function automatic logic model_lvl(logic lvl0, logic [1:0] ac, logic [1:0] ax,
                                     int rx, int c0, int t);
    logic l;
    l = lvl0;
    for (int j = 0; j < t; j++) begin
      int q;
      q = (c0 + j) % (cfg_rc + 1);
      if (q == cfg_rc)  l = apply_act(ac, l);
      else if (q == rx) l = apply_act(ax, l);
    end
    return l;
  endfunction

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      total++;
      if (wave_a !== it.a || wave_b !== it.b || int'(count) != it.cnt) begin
        bad++;
        $display("FAIL %s: a=%b b=%b cnt=%0d expected a=%b b=%b cnt=%0d",
                 it.tag, wave_a, wave_b, count, it.a, it.b, it.cnt);
      end
    end
  end

  task automatic bus_write(input int addr, input logic [31:0] data);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = addr[2:0]; wr_data = data;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic set_mode(input logic [2:0] sel, input logic we,
                          input logic [1:0] ax, input logic [1:0] ac, input logic [1:0] at,
                          input logic [1:0] bx, input logic [1:0] bc, input logic [1:0] bt);
    m_sel = sel; m_we = we;
    a_x = ax; a_c = ac; a_t = at; b_x = bx; b_c = bc; b_t = bt;
    bus_write(0, {16'h0, bt, bc, bx, at, ac, ax, we, sel});
  endtask

  task automatic set_cmp(input int ra, input int rb, input int rc);
    cfg_ra = ra; cfg_rb = rb; cfg_rc = rc;
    bus_write(1, ra); bus_write(2, rb); bus_write(3, rc);
  endtask

  // command write, then n checked cycles; nd is the tick divide (0 = no tick)
  task automatic run_cmd(input bit en, input bit dis, input bit trg,
                         input int n, input int nd, input string tag);
    logic la0, lb0;
    int   c0;
    bit   e0, run_after;
    la0 = trg ? apply_act(a_t, cur_a) : cur_a;
    lb0 = trg ? apply_act(b_t, cur_b) : cur_b;
    c0  = trg ? 0 : cur_cnt;
    e0  = cur_run && !trg && m_we;
    run_after = dis ? 1'b0 : (en ? 1'b1 : cur_run);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = 3'd4; wr_data = {29'h0, trg, dis, en};
    @(posedge clk); #1;
    wr_en = 1'b0;
    for (int k = 0; k <= n; k++) begin
      int t;
      item_t it;
      t = e0 ? 1 : 0;
      if (run_after && m_we && nd != 0) t += trg ? (k / nd) : k;
      it.a   = model_lvl(la0, a_c, a_x, cfg_ra, c0, t);
      it.b   = model_lvl(lb0, b_c, b_x, cfg_rb, c0, t);
      it.cnt = (c0 + t) % (cfg_rc + 1);
      it.tag = tag;
      if (k < n) sb_q.push_back(it);
      else begin
        cur_a = it.a; cur_b = it.b; cur_cnt = it.cnt;
      end
    end
    cur_run = run_after;
    repeat (n - 1) @(posedge clk);
  endtask

  task automatic stop_all();
    run_cmd(1'b0, 1'b1, 1'b1, 4, 1, "R7");
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    total++;
    // R1
    if (wave_a !== 1'b0 || wave_b !== 1'b0 || count !== 16'd0) begin
      bad++;
      $display("FAIL R1: a=%b b=%b cnt=%0d expected a=0 b=0 cnt=0", wave_a, wave_b, count);
    end

    // R4 R2: A normal polarity, B inverted, different duties
    set_mode(3'd0, 1'b1, 2'b10, 2'b01, 2'b01, 2'b01, 2'b10, 2'b10);
    set_cmp(2, 1, 4);
    run_cmd(1'b1, 1'b0, 1'b1, 20, 1, "R4");
    run_cmd(1'b0, 1'b1, 1'b1, 10, 1, "R7");   // trigger + stop
    run_cmd(1'b1, 1'b1, 1'b1, 6, 1, "R7");    // stop wins over start

    // R3 tick selects
    set_mode(3'd1, 1'b1, 2'b10, 2'b01, 2'b01, 2'b01, 2'b10, 2'b10);
    run_cmd(1'b1, 1'b0, 1'b1, 24, 2, "R3");
    stop_all();
    set_mode(3'd2, 1'b1, 2'b10, 2'b01, 2'b01, 2'b01, 2'b10, 2'b10);
    set_cmp(1, 1, 2);
    run_cmd(1'b1, 1'b0, 1'b1, 40, 8, "R3");
    stop_all();
    set_mode(3'd4, 1'b1, 2'b10, 2'b01, 2'b01, 2'b01, 2'b10, 2'b10);
    run_cmd(1'b1, 1'b0, 1'b1, 8, 0, "R3");
    stop_all();
    slow_tick = 1'b1;
    run_cmd(1'b1, 1'b0, 1'b1, 10, 1, "R3");
    stop_all();
    slow_tick = 1'b0;

    // R8 duty zero and duty full: no compare actions
    set_mode(3'd0, 1'b1, 2'b00, 2'b00, 2'b10, 2'b00, 2'b00, 2'b01);
    set_cmp(0, 4, 4);
    run_cmd(1'b1, 1'b0, 1'b1, 15, 1, "R8");
    stop_all();

    // R4 toggle
    set_mode(3'd0, 1'b1, 2'b00, 2'b11, 2'b01, 2'b11, 2'b00, 2'b10);
    set_cmp(0, 1, 3);
    run_cmd(1'b1, 1'b0, 1'b1, 20, 1, "R4");
    stop_all();

    // R6 period compare over duty compare
    set_mode(3'd0, 1'b1, 2'b10, 2'b01, 2'b01, 2'b01, 2'b10, 2'b10);
    set_cmp(3, 3, 3);
    run_cmd(1'b1, 1'b0, 1'b1, 12, 1, "R6");
    stop_all();

    // R6 trigger over period compare: retrigger while count equals period
    set_mode(3'd0, 1'b1, 2'b00, 2'b01, 2'b10, 2'b00, 2'b10, 2'b01);
    set_cmp(0, 0, 3);
    run_cmd(1'b1, 1'b0, 1'b1, 7, 1, "R6");
    run_cmd(1'b1, 1'b0, 1'b1, 5, 1, "R6");
    stop_all();

    // R9 waveform disabled
    set_mode(3'd0, 1'b0, 2'b10, 2'b01, 2'b01, 2'b01, 2'b10, 2'b10);
    set_cmp(2, 1, 4);
    run_cmd(1'b1, 1'b0, 1'b1, 8, 1, "R9");
    stop_all();

    // R7 stop freezes, start resumes
    set_mode(3'd0, 1'b1, 2'b10, 2'b01, 2'b01, 2'b01, 2'b10, 2'b10);
    run_cmd(1'b1, 1'b0, 1'b1, 3, 1, "R7");
    run_cmd(1'b0, 1'b1, 1'b0, 4, 1, "R7");
    run_cmd(1'b1, 1'b0, 1'b0, 6, 1, "R7");
    stop_all();

    repeat (3) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule